// File: doc/BRIEF.md
# Buffered Serial Frame Transmitter

This block serialises bytes onto a single output line. A host drops one byte at a time into a one-entry holding buffer with a write strobe. When the shifter is idle, that byte moves across one cycle later. When a frame is already on the line, the byte moves across as its final stop bit ends, so consecutive frames follow one another with no idle time. The host polls a buffer-empty flag, or takes a level interrupt request derived from it, before each write.

Each frame is one low start bit, then 5 to 8 data bits sent least significant first, then one or two high stop bits. Two timing sources are available. In asynchronous mode, a reloadable 12-bit divider produces a base tick, and every bit spans 16 base ticks, or 8 at double speed. In synchronous mode, each bit advances on a chosen edge of an external clock that first passes through a two-flop synchroniser.

An enable input hands the output pin to the transmitter. While the pin is not in use, it copies an ordinary port value instead. A completion flag reports that the line has drained.

Top module: `sertx_top`

## Requirements
- R1: In reset, serial_out is 1, buf_empty is 1, tx_done is 0 and irq is 0.
- R2: With tx_en = 0, no frame in progress and the buffer empty, serial_out equals port_out of the previous cycle. With tx_en = 1 and nothing to send, serial_out rests at 1.
- R3: A frame is a 0 start bit, then the data bits LSB first, then one stop bit of 1 when two_stop = 0 or two such bits when two_stop = 1.
- R4: width_sel values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Written bits above the selected width never reach the line.
- R5: A write is accepted only when wr_stb = 1, tx_en = 1 and buf_empty = 1. buf_empty drops in the following cycle. Any other write leaves the buffer and the line untouched.
- R6: A buffered byte enters the shifter one cycle after the write when the line is idle. Otherwise it enters in the cycle in which the last stop bit ends, and the next start bit follows with no idle cycle.
- R7: With sync_mode = 0, each bit lasts (baud_div+1)*16 clock cycles, or (baud_div+1)*8 when dbl_speed = 1.
- R8: With sync_mode = 1, the line moves to the next bit once per edge of xclk_in, taken after two synchroniser flops. xclk_edge = 0 selects rising edges and 1 selects falling edges.
- R9: irq in a cycle equals rdy_irq_en of the previous cycle ANDed with buf_empty of the current cycle.
- R10: tx_done sets when a last stop bit ends while the buffer is empty. It clears on tc_ack or when a new frame starts. Setting wins over tc_ack.
- R11: If tx_en is cleared mid-frame, the current frame and a buffered byte are still sent in full, and only then does serial_out return to port_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter owns the pin and accepts writes |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| width_sel | input | 2 | Data bits: 0..3 select 5..8 |
| two_stop | input | 1 | 1 selects two stop bits |
| sync_mode | input | 1 | 1 selects external bit clock |
| dbl_speed | input | 1 | 8 base ticks per bit instead of 16 |
| baud_div | input | 12 | Divider reload value |
| xclk_in | input | 1 | External bit clock (asynchronous) |
| xclk_edge | input | 1 | 0 rising, 1 falling edge of xclk_in |
| port_out | input | 1 | Ordinary port value for the pin |
| rdy_irq_en | input | 1 | Interrupt enable for buffer-empty |
| tc_ack | input | 1 | Clears tx_done |
| serial_out | output | 1 | Serial line / pin value |
| buf_empty | output | 1 | Holding buffer can take a byte |
| tx_done | output | 1 | Line drained, buffer empty |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
Single polled bytes are sent at every width, with one and with two stop bits. This separates the frame layout from the masking of unused high bits. Unpolled bursts and writes made while disabled tell accepted writes from ignored ones. Back-to-back polled writes show whether any gap appears between frames. Separate runs at double speed, at different divider values and in synchronous mode on each clock edge isolate the timing source. Dropping the enable in mid-frame, with a byte still queued, shows when the pin is handed back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = DATA_MAX + 3;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef logic [1:0] wsel_t;

  typedef struct packed {
    logic [FRAME_MAX-1:0] bits;
    logic [LEN_W-1:0]     len;
  } frame_t;

  function automatic int data_bits(wsel_t s);
    return 5 + int'(s);
  endfunction

  // start bit at index 0, data LSB first, ones above
  function automatic frame_t build_frame(logic [DATA_MAX-1:0] d, wsel_t s,
                                         logic two);
    frame_t f;
    int w;
    w = data_bits(s);
    f.bits = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      f.bits[1+i] = (i < w) ? d[i] : 1'b1;
    f.len = LEN_W'(w + 2 + int'(two));
    return f;
  endfunction
endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
  parameter int DIV_W       = 12,
  parameter int OS_NORM     = 16,
  parameter int OS_FAST     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sync_mode,
  input  logic             dbl_speed,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             xclk_in,
  input  logic             xclk_edge,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(OS_NORM);
  localparam logic [SUB_W-1:0] LIM_N = SUB_W'(OS_NORM - 1);
  localparam logic [SUB_W-1:0] LIM_F = SUB_W'(OS_FAST - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [SUB_W-1:0] sub_cnt;
  logic [SUB_W-1:0] sub_lim;
  logic             base_tick;
  logic             sub_end;
  logic [SYNC_STAGES:0] xs;
  logic             rise, fall, ext_tick;

  assign sub_lim   = dbl_speed ? LIM_F : LIM_N;
  assign base_tick = run && !sync_mode && (div_cnt == baud_div);
  assign sub_end   = (sub_cnt >= sub_lim);

  always_ff @(posedge clk) begin
    if (rst || !run || sync_mode) begin
      div_cnt <= '0;
      sub_cnt <= '0;
    end else if (base_tick) begin
      div_cnt <= '0;
      sub_cnt <= sub_end ? '0 : sub_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // synchroniser chain plus one history flop for edge detection
  generate
    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) xs[0] <= 1'b0;
          else     xs[0] <= xclk_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) xs[g] <= 1'b0;
          else     xs[g] <= xs[g-1];
      end
    end
  endgenerate

  assign rise     = xs[SYNC_STAGES-1] & ~xs[SYNC_STAGES];
  assign fall     = ~xs[SYNC_STAGES-1] & xs[SYNC_STAGES];
  assign ext_tick = run && (xclk_edge ? fall : rise);
  assign bit_tick = sync_mode ? ext_tick : (base_tick && sub_end);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_en,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          accept
);
  assign accept = wr_stb && tx_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take)   full <= 1'b0;
      if (accept) begin
        full <= 1'b1;
        data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_tick,
  input  logic                hold_full,
  input  logic [DATA_MAX-1:0] hold_data,
  input  wsel_t               width_sel,
  input  logic                two_stop,
  output logic                busy,
  output logic                line_bit,
  output logic                take,
  output logic                frame_end
);
  logic [FRAME_MAX-1:0] frm;
  logic [LEN_W-1:0]     left;
  frame_t               nf;

  assign nf        = build_frame(hold_data, width_sel, two_stop);
  assign frame_end = busy && bit_tick && (left == LEN_W'(1));
  assign take      = hold_full && (!busy || frame_end);
  assign line_bit  = busy ? frm[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      frm  <= '1;
      left <= '0;
    end else if (take) begin
      busy <= 1'b1;
      frm  <= nf.bits;
      left <= nf.len;
    end else if (busy && bit_tick) begin
      frm  <= {1'b1, frm[FRAME_MAX-1:1]};
      left <= left - 1'b1;
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       width_sel,
  input  logic             two_stop,
  input  logic             sync_mode,
  input  logic             dbl_speed,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             xclk_in,
  input  logic             xclk_edge,
  input  logic             port_out,
  input  logic             rdy_irq_en,
  input  logic             tc_ack,
  output logic             serial_out,
  output logic             buf_empty,
  output logic             tx_done,
  output logic             irq
);
  logic                bit_tick;
  logic                busy, line_bit, take, frame_end;
  logic                hold_full, accept;
  logic [DATA_MAX-1:0] hold_data;
  logic                full_next, own;

  sertx_tick #(.DIV_W(DIV_W), .OS_NORM(OS_NORM), .OS_FAST(OS_FAST),
               .SYNC_STAGES(2)) tick_i (
    .clk(clk), .rst(rst), .run(busy), .sync_mode(sync_mode),
    .dbl_speed(dbl_speed), .baud_div(baud_div), .xclk_in(xclk_in),
    .xclk_edge(xclk_edge), .bit_tick(bit_tick));

  sertx_hold #(.DW(DATA_MAX)) hold_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .tx_en(tx_en), .take(take), .full(hold_full), .data(hold_data),
    .accept(accept));

  sertx_shift shift_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .hold_full(hold_full),
    .hold_data(hold_data), .width_sel(width_sel), .two_stop(two_stop),
    .busy(busy), .line_bit(line_bit), .take(take), .frame_end(frame_end));

  assign buf_empty = ~hold_full;
  assign full_next = (hold_full & ~take) | accept;
  assign own       = tx_en | busy | hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      serial_out <= 1'b1;
      tx_done    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      serial_out <= own ? line_bit : port_out;
      irq        <= rdy_irq_en & ~full_next;
      if (take)           tx_done <= 1'b0;
      else if (frame_end) tx_done <= 1'b1;
      else if (tc_ack)    tx_done <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic wr_stb,
  input logic port_out,
  input logic rdy_irq_en,
  input logic tc_ack,
  input logic serial_out,
  input logic buf_empty,
  input logic tx_done,
  input logic irq,
  input logic busy,
  input logic hold_full,
  input logic take,
  input logic frame_end
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R5
  accept_clears_empty_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) (wr_stb && tx_en && buf_empty) |=> !buf_empty);

  // R5
  full_write_ignored_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) (wr_stb && !buf_empty && !take) |=> !buf_empty);

  // R9
  irq_tracks_empty_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) rdy_irq_en |=> (irq == buf_empty));

  // R9
  irq_masked_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) !rdy_irq_en |=> !irq);

  // R6
  no_gap_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) (frame_end && hold_full) |=> busy);

  // R3
  start_low_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) take |=> ##1 (serial_out == 1'b0));

  // R10
  ack_clears_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) (tc_ack && !frame_end) |=> !tx_done);

  // R2
  port_passthru_chk: assert property (@(posedge clk)
    disable iff (rst || !armed) (!tx_en && !busy && !hold_full)
      |=> (serial_out == $past(port_out)));
endmodule

bind sertx_top sertx_chk chk_i (
  .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .port_out(port_out),
  .rdy_irq_en(rdy_irq_en), .tc_ack(tc_ack), .serial_out(serial_out),
  .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq), .busy(busy),
  .hold_full(hold_full), .take(take), .frame_end(frame_end));

// File: tb/sertx_top_tb.sv
module sertx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 0, wr_stb = 0, two_stop = 0, sync_mode = 0;
  logic        dbl_speed = 0, xclk_in = 0, xclk_edge = 0, port_out = 0;
  logic        rdy_irq_en = 0, tc_ack = 0;
  logic [7:0]  wr_data = 0;
  logic [1:0]  width_sel = 2'd3;
  logic [11:0] baud_div = 12'd1;
  logic        serial_out, buf_empty, tx_done, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  logic  xgen_on = 0;
  int    xgen_cnt = 0;

  always #10 clk = ~clk;

  sertx_top dut_i (.*);

  // ---------------- behavioural reference model ----------------
  byte unsigned q[$];
  bit           fbits[$];
  bit m_busy, m_out, m_done, m_irq, m_empty;
  int dc, sub, s1, s2, s3;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); fbits.delete();
      m_busy = 0; m_out = 1; m_done = 0; m_irq = 0; m_empty = 1;
      dc = 0; sub = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int  lim, w;
      bit  bt, endf, tk, edge_ok, nout;
      lim = dbl_speed ? 8 : 16;
      edge_ok = xclk_edge ? (s2 == 0 && s3 == 1) : (s2 == 1 && s3 == 0);
      if (sync_mode) bt = m_busy && edge_ok;
      else bt = m_busy && dc == int'(baud_div) && sub >= lim - 1;
      endf = bt && fbits.size() == 1;
      tk = q.size() == 1 && (!m_busy || endf);
      if (tx_en || m_busy || q.size() != 0) nout = m_busy ? fbits[0] : 1'b1;
      else nout = port_out;
      if (m_busy && !sync_mode) begin
        if (dc == int'(baud_div)) begin
          dc = 0;
          sub = (sub >= lim - 1) ? 0 : sub + 1;
        end else dc++;
      end else begin dc = 0; sub = 0; end
      if (tk) begin
        w = 5 + int'(width_sel);
        fbits.delete();
        fbits.push_back(1'b0);
        for (int i = 0; i < w; i++) fbits.push_back(q[0][i]);
        fbits.push_back(1'b1);
        if (two_stop) fbits.push_back(1'b1);
        m_busy = 1;
        void'(q.pop_front());
      end else if (bt) begin
        void'(fbits.pop_front());
        if (fbits.size() == 0) m_busy = 0;
      end
      if (!tk && wr_stb && tx_en && q.size() == 0) q.push_back(wr_data);
      if (tk) m_done = 0;
      else if (endf) m_done = 1;
      else if (tc_ack) m_done = 0;
      m_empty = q.size() == 0;
      m_irq = rdy_irq_en && m_empty;
      m_out = nout;
      s3 = s2; s2 = s1; s1 = int'(xclk_in);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what,
               act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(serial_out == m_out,  cur_req, "serial_out", serial_out, m_out);
      check(buf_empty == m_empty, "R5", "buf_empty", buf_empty, m_empty);
      check(tx_done == m_done,    "R10", "tx_done", tx_done, m_done);
      check(irq == m_irq,         "R9", "irq", irq, m_irq);
    end
    if (xgen_on) begin
      xgen_cnt++;
      if (xgen_cnt >= 5) begin xgen_cnt = 0; xclk_in = ~xclk_in; end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(byte unsigned b);
    while (!buf_empty) @(negedge clk);
    wr_data = b; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic drain();
    while (!(tx_done && buf_empty)) @(negedge clk);
    tc_ack = 1;
    @(negedge clk);
    tc_ack = 0;
    wait_cycles(3);
  endtask

  initial begin
    wait_cycles(4);
    // R1: reset values, sampled while reset is held
    check(serial_out == 1'b1, "R1", "serial_out", serial_out, 1);
    check(buf_empty == 1'b1,  "R1", "buf_empty", buf_empty, 1);
    check(tx_done == 1'b0,    "R1", "tx_done", tx_done, 0);
    check(irq == 1'b0,        "R1", "irq", irq, 0);
    rst = 0;

    // R2: port passthrough while disabled; R5: a disabled write is ignored
    cur_req = "R2";
    port_out = 1; wait_cycles(3);
    port_out = 0; wait_cycles(3);
    wr_data = 8'h00; wr_stb = 1; wait_cycles(1); wr_stb = 0;
    wait_cycles(3);
    check(buf_empty == 1'b1, "R5", "buf_empty after disabled write",
          buf_empty, 1);
    tx_en = 1; wait_cycles(4);

    // R3 / R4: every width, both stop settings
    cur_req = "R4";
    rdy_irq_en = 1;
    for (int ws = 0; ws < 4; ws++) begin
      for (int st = 0; st < 2; st++) begin
        width_sel = 2'(ws); two_stop = 1'(st);
        send(8'hA5 ^ 8'(ws * 17 + st));
        drain();
      end
    end

    // R6: back-to-back frames with polling
    cur_req = "R6";
    width_sel = 2'd3; two_stop = 0;
    send(8'h3C); send(8'hC3); send(8'h81);
    drain();

    // R5: burst without polling, second write must be dropped
    cur_req = "R5";
    wr_data = 8'h55; wr_stb = 1; wait_cycles(1);
    wr_data = 8'hFF; wait_cycles(1);
    wr_data = 8'h0F; wait_cycles(1);
    wr_stb = 0;
    drain();

    // R7: double speed and other divider values
    cur_req = "R7";
    dbl_speed = 1; baud_div = 12'd0; send(8'h96); drain();
    dbl_speed = 0; baud_div = 12'd3; send(8'h69); drain();
    baud_div = 12'd1;

    // R10: acknowledge during a frame, then completion
    cur_req = "R10";
    send(8'h12);
    wait_cycles(20); tc_ack = 1; wait_cycles(1); tc_ack = 0;
    drain();

    // R8: external clock, rising then falling edges
    cur_req = "R8";
    sync_mode = 1; xgen_on = 1;
    xclk_edge = 0; send(8'hB4); send(8'h4B); drain();
    xclk_edge = 1; two_stop = 1; send(8'hE7); drain();
    sync_mode = 0; xgen_on = 0; two_stop = 0;

    // R9: interrupt masked
    cur_req = "R9";
    rdy_irq_en = 0; send(8'h77); wait_cycles(30); rdy_irq_en = 1;
    drain();

    // R11: drop enable mid-frame with a byte queued
    cur_req = "R11";
    send(8'hF0); send(8'h0A);
    wait_cycles(40);
    tx_en = 0; port_out = 0;
    drain();
    wait_cycles(5);
    check(serial_out == port_out, "R11", "pin back to port",
          serial_out, port_out);
    finish_run();
  end
endmodule